// File: doc/BRIEF.md
# Bus Abort Status Capture Unit

This block sits beside a shared system bus used by up to four masters. Each cycle it looks at the access on the bus and decides whether the access must be aborted: either the address falls outside every defined memory region, or the address is not aligned to the transfer size. A faulting access produces a one-cycle abort pulse that goes to every master at once. A second, per-master qualified vector carries the same pulse only on the line of the master that issued the access.

On each abort the unit records diagnostic state for software. It keeps the full 32-bit faulting address, the transfer size, the access kind and the two cause flags. A one-hot field names the master of the latest abort. A sticky field collects every other master that aborted since software last read the status word. The same small register port also holds a boot remap flag, which write-one-to-toggle commands flip so that software can return to the post-reset memory map.

The control path is a two-state machine. `ST_IDLE` means no abort is being signalled. `ST_ABORT` drives the abort outputs. The machine moves IDLE→ABORT on a faulting access, ABORT→ABORT on a back-to-back fault, ABORT→IDLE when the next cycle has no fault, and IDLE→IDLE otherwise.

Top module: `bus_abort_monitor`

## Requirements
- R1: An access with `bus_valid` high aborts exactly when its address lies in no region [base, limit], or it is misaligned (size 01=halfword with address bit 0 set, size 10 or 11=word with address bits 1:0 non-zero, size 00=byte never misaligned). Cycles with `bus_valid` low never abort.
- R2: `abort_any` is high for exactly the one cycle after the clock edge that samples a faulting access. `abort_to` is then one-hot on the issuing master's bit (bit i = master index i) and is zero whenever `abort_any` is low.
- R3: Register select 0 reads the full 32-bit address of the most recent faulting access.
- R4: Status bit 4 is set when the latest abort had an undefined address. Status bit 5 is set when it was misaligned. Both bits may be set together.
- R5: Status bits 1:0 hold the size of the latest faulting access (00 byte, 01 halfword, 10 word). Bits 3:2 hold its kind (00 data read, 01 data write, 10 code fetch).
- R6: Status bits 11:8 are one-hot on the master of the latest abort.
- R7: Status bits 19:16 are sticky, one per master. When a new abort arrives, the previous last master is added to them, and the new master is always removed. The sticky and last-master fields therefore never share a set bit.
- R8: Select 2 holds the remap flag in bit 0, which is also driven on `remap_zero`. A write to select 2 with data bit 0 set toggles it. A write with bit 0 clear leaves it unchanged.
- R9: A read of select 1 (status) clears the sticky field from the following cycle. The address, size, kind, cause and last-master fields keep their values until the next abort.
- R10: After reset, the status word, the abort address, the remap flag and both abort outputs are all zero.
- R11: A status read in the same cycle as a new abort returns the values from before that abort. After that cycle, the sticky field holds only the previous last master, unless that master is the new one.
- R12: Read data appears on `cfg_rdata` one cycle after `cfg_rd`. Select 3 reads zero. Writes to selects 0, 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | An access is present on the bus this cycle |
| bus_master | input | 2 | Index of the issuing master |
| bus_addr | input | 32 | Access address |
| bus_size | input | 2 | Transfer size code |
| bus_kind | input | 2 | Access kind code |
| abort_any | output | 1 | Abort pulse broadcast to all masters |
| abort_to | output | 4 | Abort pulse qualified per master |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| remap_zero | output | 1 | Boot remap flag |

## Verification
The bench drives several kinds of access, and each pair separates two things the detector could confuse:
- A correctly aligned access inside a region, against the same region with a misaligned address: this shows that alignment is judged per size.
- An undefined but aligned byte, against an address that is both undefined and misaligned: this separates the two cause bits.
- Two back-to-back faults from the same master: this shows the last-master and sticky fields excluding each other.
- A status read in the same cycle as a new abort: this separates the value read from the value cleared.

Remap writes with data bit 0 set and clear show the difference between toggling and ignoring.

// File: rtl/bam_pkg.sv
package bam_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ABORT = 1'b1
    } ctl_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;
    localparam logic [1:0] SEL_REMAP  = 2'd2;

    localparam int STAT_SIZE_LSB = 0;
    localparam int STAT_KIND_LSB = 2;
    localparam int STAT_UNDEF    = 4;
    localparam int STAT_MISAL    = 5;
    localparam int STAT_LAST_LSB = 8;
    localparam int STAT_SAVE_LSB = 16;

endpackage

// File: rtl/bam_decode.sv
module bam_decode #(
    parameter int AW   = 32,
    parameter int NREG = 3,
    parameter logic [NREG*AW-1:0] REGION_BASE  = '0,
    parameter logic [NREG*AW-1:0] REGION_LIMIT = '0
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          undef,
    output logic          misal
);
    import bam_pkg::*;

    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        localparam logic [AW-1:0] LO = REGION_BASE[g*AW +: AW];
        localparam logic [AW-1:0] HI = REGION_LIMIT[g*AW +: AW];
        assign hit[g] = (addr >= LO) && (addr <= HI);
    end

    assign undef = ~|hit;

    always_comb begin
        unique case (size)
            SZ_BYTE: misal = 1'b0;
            SZ_HALF: misal = addr[0];
            default: misal = |addr[1:0];
        endcase
    end

endmodule

// File: rtl/bam_history.sv
module bam_history #(
    parameter int NMST = 4,
    localparam int MIDX = (NMST > 1) ? $clog2(NMST) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort_now,
    input  logic [MIDX-1:0] mst_idx,
    input  logic            clr,
    output logic [NMST-1:0] last_q,
    output logic [NMST-1:0] saved_q
);
    logic [NMST-1:0] new_oh;
    logic [NMST-1:0] saved_base;

    always_comb begin
        new_oh = '0;
        new_oh[mst_idx] = 1'b1;
        saved_base = clr ? '0 : saved_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            saved_q <= '0;
        end else if (abort_now) begin
            last_q  <= new_oh;
            saved_q <= (saved_base | last_q) & ~new_oh;
        end else begin
            saved_q <= saved_base;
        end
    end

endmodule

// File: rtl/bam_remap.sv
module bam_remap (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    output logic remap_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            remap_q <= 1'b0;
        else if (toggle)
            remap_q <= ~remap_q;
    end
endmodule

// File: rtl/bus_abort_monitor.sv
module bus_abort_monitor #(
    parameter int NMST = 4,
    parameter int AW   = 32,
    parameter int NREG = 3,
    parameter logic [NREG*AW-1:0] REGION_BASE  = {32'hFFFF_F000, 32'h0020_0000, 32'h0000_0000},
    parameter logic [NREG*AW-1:0] REGION_LIMIT = {32'hFFFF_FFFF, 32'h0020_3FFF, 32'h0000_FFFF},
    localparam int MIDX = (NMST > 1) ? $clog2(NMST) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic [MIDX-1:0] bus_master,
    input  logic [AW-1:0]   bus_addr,
    input  logic [1:0]      bus_size,
    input  logic [1:0]      bus_kind,
    output logic            abort_any,
    output logic [NMST-1:0] abort_to,
    input  logic            cfg_rd,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    output logic            remap_zero
);
    import bam_pkg::*;

    ctl_state_e state_q, state_nx;

    logic          dec_undef, dec_misal, fault_now;
    logic [AW-1:0] addr_q;
    logic [1:0]    size_q, kind_q;
    logic          undef_q, misal_q;
    logic [NMST-1:0] last_q, saved_q;
    logic [31:0]   status_w;
    logic          stat_clr, remap_tgl;
    logic          unused_wdata;

    assign unused_wdata = ^cfg_wdata[31:1];

    bam_decode #(
        .AW(AW), .NREG(NREG),
        .REGION_BASE(REGION_BASE), .REGION_LIMIT(REGION_LIMIT)
    ) u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .undef(dec_undef),
        .misal(dec_misal)
    );

    assign fault_now = bus_valid && (dec_undef || dec_misal);
    assign stat_clr  = cfg_rd && (cfg_sel == SEL_STATUS);
    assign remap_tgl = cfg_wr && (cfg_sel == SEL_REMAP) && cfg_wdata[0];

    // Control state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  state_nx = fault_now ? ST_ABORT : ST_IDLE;
            ST_ABORT: state_nx = fault_now ? ST_ABORT : ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        abort_any = (state_q == ST_ABORT);
        abort_to  = abort_any ? last_q : '0;
    end

    // Capture of the faulting access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            kind_q  <= '0;
            undef_q <= 1'b0;
            misal_q <= 1'b0;
        end else if (fault_now) begin
            addr_q  <= bus_addr;
            size_q  <= bus_size;
            kind_q  <= bus_kind;
            undef_q <= dec_undef;
            misal_q <= dec_misal;
        end
    end

    bam_history #(.NMST(NMST)) u_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort_now(fault_now),
        .mst_idx  (bus_master),
        .clr      (stat_clr),
        .last_q   (last_q),
        .saved_q  (saved_q)
    );

    bam_remap u_remap (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (remap_tgl),
        .remap_q(remap_zero)
    );

    always_comb begin
        status_w = '0;
        status_w[STAT_SIZE_LSB +: 2]    = size_q;
        status_w[STAT_KIND_LSB +: 2]    = kind_q;
        status_w[STAT_UNDEF]            = undef_q;
        status_w[STAT_MISAL]            = misal_q;
        status_w[STAT_LAST_LSB +: NMST] = last_q;
        status_w[STAT_SAVE_LSB +: NMST] = saved_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            unique case (cfg_sel)
                SEL_ADDR:   cfg_rdata <= 32'(addr_q);
                SEL_STATUS: cfg_rdata <= status_w;
                SEL_REMAP:  cfg_rdata <= {31'd0, remap_zero};
                default:    cfg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/bam_checker.sv
module bam_checker #(
    parameter int NMST = 4,
    parameter int AW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_valid,
    input logic            fault,
    input logic [AW-1:0]   bus_addr,
    input logic [AW-1:0]   addr_q,
    input logic            abort_any,
    input logic [NMST-1:0] abort_to,
    input logic [NMST-1:0] last_q,
    input logic [NMST-1:0] saved_q,
    input logic            stat_rd,
    input logic            remap_wr1,
    input logic            remap_zero
);
    // R2: one-hot qualified line while aborting
    a_r2_onehot_target: assert property (@(posedge clk) disable iff (!rst_n)
        abort_any |-> $onehot(abort_to));

    // R2: silent qualified lines outside a pulse
    a_r2_quiet_target: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_any |-> (abort_to == '0));

    // R1 / R3: fault produces pulse and address capture
    a_r3_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && fault) |=> (abort_any && addr_q == $past(bus_addr)));

    // R1: no fault, no pulse
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && fault) |=> !abort_any);

    // R7: sticky and last-master fields exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q & saved_q) == '0);

    // R8: write of one toggles remap
    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        remap_wr1 |=> (remap_zero != $past(remap_zero)));

    // R9: status read without new abort empties sticky field
    a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(bus_valid && fault)) |=> (saved_q == '0));
endmodule

bind bus_abort_monitor bam_checker #(.NMST(NMST), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .fault     (dec_undef | dec_misal),
    .bus_addr  (bus_addr),
    .addr_q    (addr_q),
    .abort_any (abort_any),
    .abort_to  (abort_to),
    .last_q    (last_q),
    .saved_q   (saved_q),
    .stat_rd   (stat_clr),
    .remap_wr1 (remap_tgl),
    .remap_zero(remap_zero)
);

// File: tb/bus_abort_monitor_tb.sv
module bus_abort_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [1:0]  bus_master = '0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [1:0]  bus_kind = '0;
    logic        abort_any;
    logic [3:0]  abort_to;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        remap_zero;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // expected model
    logic [3:0]  exp_q[$];
    logic [31:0] m_addr = '0;
    logic [1:0]  m_size = '0, m_kind = '0;
    logic        m_und = 1'b0, m_mis = 1'b0;
    logic [3:0]  m_last = '0, m_saved = '0;
    logic        mon_v;
    logic [31:0] rd_val;

    always #2 clk = ~clk;

    bus_abort_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_master(bus_master), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_kind(bus_kind),
        .abort_any(abort_any), .abort_to(abort_to),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .remap_zero(remap_zero)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic undef_of(logic [31:0] a);
        return !((a <= 32'h0000_FFFF) ||
                 (a >= 32'h0020_0000 && a <= 32'h0020_3FFF) ||
                 (a >= 32'hFFFF_F000));
    endfunction

    function automatic logic misal_of(logic [31:0] a, logic [1:0] s);
        if (s == 2'd0) return 1'b0;
        if (s == 2'd1) return a[0];
        return a[1:0] != 2'd0;
    endfunction

    function automatic logic [31:0] status_exp();
        return {12'd0, m_saved, 4'd0, m_last, 2'd0, m_mis, m_und, m_kind, m_size};
    endfunction

    // model update on a driven access
    task automatic model_access(logic [1:0] m, logic [31:0] a, logic [1:0] s, logic [1:0] k);
        logic u, x;
        logic [3:0] oh;
        u = undef_of(a);
        x = misal_of(a, s);
        oh = 4'b1 << m;
        exp_q.push_back((u || x) ? oh : 4'd0);
        if (u || x) begin
            m_saved = (m_saved | m_last) & ~oh;
            m_last = oh;
            m_addr = a; m_size = s; m_kind = k; m_und = u; m_mis = x;
        end
    endtask

    task automatic drive(logic [1:0] m, logic [31:0] a, logic [1:0] s, logic [1:0] k);
        @(negedge clk);
        bus_valid = 1'b1; bus_master = m; bus_addr = a; bus_size = s; bus_kind = k;
        model_access(m, a, s, k);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0;
        cfg_rd = 1'b0;
        cfg_wr = 1'b0;
    endtask

    task automatic read_reg(logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b0;
        cfg_rd = 1'b1; cfg_sel = sel;
        @(posedge clk); #1;
        d = cfg_rdata;
        if (sel == 2'd1) m_saved = '0;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic write_reg(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        mon_v = bus_valid && rst_n;
        #1;
        if (mon_v) begin
            if (exp_q.size() == 0) begin
                chk("R2 scoreboard underflow", 32'd1, 32'd0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                chk("R1/R2 abort_to", {28'd0, abort_to}, {28'd0, e});
                chk("R2 abort_any", {31'd0, abort_any}, {31'd0, (e != 4'd0)});
            end
        end else if (rst_n && !done) begin
            if (abort_any !== 1'b0) chk("R2 pulse length", {31'd0, abort_any}, 32'd0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 abort_any", {31'd0, abort_any}, 32'd0);
        chk("R10 remap_zero", {31'd0, remap_zero}, 32'd0);
        read_reg(2'd1, rd_val); chk("R10 status", rd_val, 32'd0);
        read_reg(2'd0, rd_val); chk("R10 address", rd_val, 32'd0);

        // R1 good accesses, no abort
        drive(2'd0, 32'h0000_0100, 2'd2, 2'd0);
        drive(2'd1, 32'h0020_0002, 2'd1, 2'd1);
        // R1 misaligned word in region1 by master1
        drive(2'd1, 32'h0020_0002, 2'd2, 2'd1);
        // R1/R4 undefined byte fetch by master2
        drive(2'd2, 32'h0010_0000, 2'd0, 2'd2);
        idle(); idle();

        read_reg(2'd0, rd_val); chk("R3 abort address", rd_val, 32'h0010_0000);
        begin
            logic [31:0] e;
            e = status_exp();
            read_reg(2'd1, rd_val); chk("R4/R5/R6/R7 status", rd_val, e);
            chk("R7 sticky master1", {28'd0, rd_val[19:16]}, 32'h2);
        end
        read_reg(2'd1, rd_val); chk("R9 sticky cleared, fields held", rd_val, status_exp());
        chk("R9 last held", {28'd0, rd_val[11:8]}, 32'h4);

        // R7 back-to-back from master3, both causes on second
        drive(2'd3, 32'hFFFF_F001, 2'd1, 2'd0);
        drive(2'd3, 32'h0030_0001, 2'd2, 2'd1);
        idle(); idle();
        read_reg(2'd1, rd_val);
        chk("R7 same master excluded", rd_val, {12'd0, 4'b0100, 4'd0, 4'b1000, 2'd0, 1'b1, 1'b1, 2'd1, 2'd2});
        chk("R4 both cause bits", {30'd0, rd_val[5:4]}, 32'd3);

        // R11 read in same cycle as new abort
        drive(2'd0, 32'h0000_0003, 2'd2, 2'd0);
        idle(); idle();
        begin
            logic [31:0] pre;
            pre = status_exp();
            @(negedge clk);
            cfg_rd = 1'b1; cfg_sel = 2'd1;
            bus_valid = 1'b1; bus_master = 2'd1; bus_addr = 32'h0050_0000;
            bus_size = 2'd0; bus_kind = 2'd0;
            m_saved = '0;
            model_access(2'd1, 32'h0050_0000, 2'd0, 2'd0);
            @(posedge clk); #1;
            chk("R11 read returns pre-abort status", cfg_rdata, pre);
            idle(); idle();
        end
        read_reg(2'd1, rd_val);
        chk("R11 sticky keeps moved master", {28'd0, rd_val[19:16]}, 32'h1);
        chk("R11 last master", {28'd0, rd_val[11:8]}, 32'h2);

        // R12 writes elsewhere ignored, select 3 reads zero
        write_reg(2'd1, 32'hFFFF_FFFF);
        write_reg(2'd0, 32'hFFFF_FFFF);
        read_reg(2'd0, rd_val); chk("R12 address unchanged", rd_val, 32'h0050_0000);
        read_reg(2'd3, rd_val); chk("R12 select 3 zero", rd_val, 32'd0);

        // R8 remap toggling
        write_reg(2'd2, 32'd1);
        chk("R8 remap set", {31'd0, remap_zero}, 32'd1);
        write_reg(2'd2, 32'hFFFF_FFFE);
        read_reg(2'd2, rd_val); chk("R8 zero write ignored", rd_val, 32'd1);
        write_reg(2'd2, 32'd1);
        chk("R8 remap toggled back", {31'd0, remap_zero}, 32'd0);

        idle(); idle();
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule